// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block sits between the per-source interrupt state of an interrupt controller and its CPU-facing request lines. For every CPU it looks at all interrupt sources at once, keeps those that are eligible for that CPU, and picks the most urgent one. It then reports that source's identifier to the CPU and decides whether to raise the CPU's normal interrupt line, its fast interrupt line, or neither.

The selection runs every cycle, so any change in the state vectors (a new pending bit, a priority change, a CPU raising its running priority) is reflected on the outputs one clock later. Sources with IDs below `NUM_PRIV` are private to each CPU: their state and priority are held per CPU and their routing is implicit. The remaining sources are shared: one priority and a routing mask with one bit per CPU. Register access, acknowledge and end-of-interrupt live elsewhere and only change the input vectors seen here.

Top module: `prioArbiter`

## Requirements
- R1: A source is a candidate for CPU c only when, in CPU c's bit of the per-CPU vectors (bit index c*NUM_SRC+id), it is enabled, pending and not active.
- R2: A private source (id < NUM_PRIV) is a candidate for its CPU whatever the routing; a shared source is a candidate for CPU c only when its routing bit (index (id-NUM_PRIV)*NUM_CPU+c) is 1.
- R3: Among candidates the smallest priority value wins; on equal priority the smallest ID wins.
- R4: With no candidate, the reported ID of that CPU is 1023 and both its lines are low.
- R5: The winner's ID is reported only when its priority is strictly below the CPU's priority mask; otherwise the reported ID is 1023 and both lines are low.
- R6: A line is raised only when the winner is reported and its priority is strictly below the CPU's 9-bit running priority (256 means idle).
- R7: A line is raised only when the global group enable and the CPU's group enable for the winner's group are both set (group enable bit index = group, group bit 0 = group 0).
- R8: A group-0 winner drives the fast line when the CPU's fast-enable bit is set, otherwise the normal line; a group-1 winner always drives the normal line; never both.
- R9: Private sources use a priority held per CPU (privPrio entry c*NUM_PRIV+id); shared sources use one priority common to all CPUs.
- R10: Outputs are registered: they reflect the inputs present at the previous rising clock edge, and in reset the ID is 1023 with both lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEnable | input | NUM_CPU*NUM_SRC | Enable bit per CPU per source |
| srcPending | input | NUM_CPU*NUM_SRC | Pending bit per CPU per source |
| srcActive | input | NUM_CPU*NUM_SRC | Active bit per CPU per source |
| srcGroup | input | NUM_CPU*NUM_SRC | Group bit per CPU per source (0 = group 0) |
| sharedTarget | input | (NUM_SRC-NUM_PRIV)*NUM_CPU | Routing mask of each shared source |
| sharedPrio | input | (NUM_SRC-NUM_PRIV)*8 | Priority of each shared source |
| privPrio | input | NUM_CPU*NUM_PRIV*8 | Per-CPU priority of each private source |
| cpuPrioMask | input | NUM_CPU*8 | Priority mask of each CPU |
| cpuRunPrio | input | NUM_CPU*9 | Running priority of each CPU |
| distGrpEn | input | 2 | Global enable per group |
| cpuGrpEn | input | NUM_CPU*2 | Per-CPU enable per group |
| cpuFiqEn | input | NUM_CPU | Route group 0 to the fast line |
| curPendId | output | NUM_CPU*10 | Reported winner ID per CPU, 1023 for none |
| irqOut | output | NUM_CPU | Normal interrupt line per CPU |
| fiqOut | output | NUM_CPU | Fast interrupt line per CPU |

## Verification
The bench aims at equality cases: two sources with the same priority, where a selector that compared with less-or-equal would report the higher ID, and a winner whose priority equals the mask or the running priority, where an off-by-one gate would report or signal an interrupt it must hold back. It mixes private and shared sources so that a swapped priority bank or an ignored routing bit shows up as the wrong ID on one CPU only. Group routing is swept across both enable levels and the fast-enable bit, which catches a design that raises a line with one enable clear or sends group 1 to the fast line.

// File: rtl/prioArbPkg.sv
package prioArbPkg;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] NO_ID = 10'd1023;

  typedef struct packed {
    logic [PRIO_W:0]   prio;
    logic [ID_W-1:0]   id;
    logic              grp;
  } cand_t;

  typedef struct packed {
    logic publish;
    logic lineIrq;
    logic lineFiq;
  } gateStrobe_t;
endpackage

// File: rtl/prioArbDatapath.sv
module prioArbDatapath
  import prioArbPkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPU  = 2,
  parameter int NUM_PRIV = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_CPU*NUM_SRC-1:0]          srcEnable,
  input  logic [NUM_CPU*NUM_SRC-1:0]          srcPending,
  input  logic [NUM_CPU*NUM_SRC-1:0]          srcActive,
  input  logic [NUM_CPU*NUM_SRC-1:0]          srcGroup,
  input  logic [(NUM_SRC-NUM_PRIV)*NUM_CPU-1:0] sharedTarget,
  input  logic [(NUM_SRC-NUM_PRIV)*PRIO_W-1:0]  sharedPrio,
  input  logic [NUM_CPU*NUM_PRIV*PRIO_W-1:0]  privPrio,
  input  gateStrobe_t [NUM_CPU-1:0]           strobe,
  output logic [NUM_CPU*(PRIO_W+1)-1:0]       bestPrio,
  output logic [NUM_CPU-1:0]                  bestGrp,
  output logic [NUM_CPU*ID_W-1:0]             curPendId,
  output logic [NUM_CPU-1:0]                  irqOut,
  output logic [NUM_CPU-1:0]                  fiqOut
);
  localparam int LEAVES = 1 << $clog2(NUM_SRC);
  localparam cand_t EMPTY = '{prio: {1'b1, {PRIO_W{1'b0}}}, id: NO_ID, grp: 1'b0};

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    cand_t leaf [LEAVES];
    cand_t node [2*LEAVES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < NUM_SRC) begin : g_real
        localparam int B = c*NUM_SRC + i;
        logic [PRIO_W-1:0] srcPrio;
        logic              routed;
        if (i < NUM_PRIV) begin : g_priv
          assign srcPrio = privPrio[(c*NUM_PRIV+i)*PRIO_W +: PRIO_W];
          assign routed  = 1'b1;
        end else begin : g_shared
          assign srcPrio = sharedPrio[(i-NUM_PRIV)*PRIO_W +: PRIO_W];
          assign routed  = sharedTarget[(i-NUM_PRIV)*NUM_CPU + c];
        end
        always_comb begin
          if (srcEnable[B] && srcPending[B] && !srcActive[B] && routed)
            leaf[i] = '{prio: {1'b0, srcPrio}, id: ID_W'(i), grp: srcGroup[B]};
          else
            leaf[i] = EMPTY;
        end
      end else begin : g_pad
        assign leaf[i] = EMPTY;
      end
    end

    // Heap-ordered reduction: the left child always holds lower IDs,
    // so the right child only wins on a strictly smaller priority.
    always_comb begin
      for (int k = 0; k < LEAVES; k++) node[LEAVES+k] = leaf[k];
      for (int k = LEAVES-1; k >= 1; k--)
        node[k] = (node[2*k+1].prio < node[2*k].prio) ? node[2*k+1] : node[2*k];
      node[0] = node[1];
    end

    assign bestPrio[c*(PRIO_W+1) +: PRIO_W+1] = node[0].prio;
    assign bestGrp[c] = node[0].grp;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        curPendId[c*ID_W +: ID_W] <= NO_ID;
        irqOut[c] <= 1'b0;
        fiqOut[c] <= 1'b0;
      end else begin
        curPendId[c*ID_W +: ID_W] <= strobe[c].publish ? node[0].id : NO_ID;
        irqOut[c] <= strobe[c].lineIrq;
        fiqOut[c] <= strobe[c].lineFiq;
      end
    end
  end
endmodule

// File: rtl/prioArbControl.sv
module prioArbControl
  import prioArbPkg::*;
#(
  parameter int NUM_CPU = 2
) (
  input  logic [NUM_CPU*(PRIO_W+1)-1:0] bestPrio,
  input  logic [NUM_CPU-1:0]            bestGrp,
  input  logic [NUM_CPU*PRIO_W-1:0]     cpuPrioMask,
  input  logic [NUM_CPU*(PRIO_W+1)-1:0] cpuRunPrio,
  input  logic [1:0]                    distGrpEn,
  input  logic [NUM_CPU*2-1:0]          cpuGrpEn,
  input  logic [NUM_CPU-1:0]            cpuFiqEn,
  output gateStrobe_t [NUM_CPU-1:0]     strobe
);
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      logic [PRIO_W:0] p;
      logic            g;
      logic            below;
      logic            grpOn;
      logic            raise;
      p     = bestPrio[c*(PRIO_W+1) +: PRIO_W+1];
      g     = bestGrp[c];
      below = p < {1'b0, cpuPrioMask[c*PRIO_W +: PRIO_W]};
      grpOn = distGrpEn[g] && cpuGrpEn[c*2 + int'(g)];
      raise = below && (p < cpuRunPrio[c*(PRIO_W+1) +: PRIO_W+1]) && grpOn;
      strobe[c].publish = below;
      strobe[c].lineFiq = raise && !g && cpuFiqEn[c];
      strobe[c].lineIrq = raise && !(!g && cpuFiqEn[c]);
    end
  end
endmodule

// File: rtl/prioArbiter.sv
module prioArbiter
  import prioArbPkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPU  = 2,
  parameter int NUM_PRIV = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_CPU*NUM_SRC-1:0]            srcEnable,
  input  logic [NUM_CPU*NUM_SRC-1:0]            srcPending,
  input  logic [NUM_CPU*NUM_SRC-1:0]            srcActive,
  input  logic [NUM_CPU*NUM_SRC-1:0]            srcGroup,
  input  logic [(NUM_SRC-NUM_PRIV)*NUM_CPU-1:0] sharedTarget,
  input  logic [(NUM_SRC-NUM_PRIV)*8-1:0]       sharedPrio,
  input  logic [NUM_CPU*NUM_PRIV*8-1:0]         privPrio,
  input  logic [NUM_CPU*8-1:0]                  cpuPrioMask,
  input  logic [NUM_CPU*9-1:0]                  cpuRunPrio,
  input  logic [1:0]                            distGrpEn,
  input  logic [NUM_CPU*2-1:0]                  cpuGrpEn,
  input  logic [NUM_CPU-1:0]                    cpuFiqEn,
  output logic [NUM_CPU*10-1:0]                 curPendId,
  output logic [NUM_CPU-1:0]                    irqOut,
  output logic [NUM_CPU-1:0]                    fiqOut
);
  logic [NUM_CPU*(PRIO_W+1)-1:0] bestPrio;
  logic [NUM_CPU-1:0]            bestGrp;
  gateStrobe_t [NUM_CPU-1:0]     strobe;

  prioArbDatapath #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PRIV(NUM_PRIV)) u_dp (
    .clk(clk), .rstN(rstN),
    .srcEnable(srcEnable), .srcPending(srcPending), .srcActive(srcActive),
    .srcGroup(srcGroup), .sharedTarget(sharedTarget), .sharedPrio(sharedPrio),
    .privPrio(privPrio), .strobe(strobe),
    .bestPrio(bestPrio), .bestGrp(bestGrp),
    .curPendId(curPendId), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  prioArbControl #(.NUM_CPU(NUM_CPU)) u_ctl (
    .bestPrio(bestPrio), .bestGrp(bestGrp),
    .cpuPrioMask(cpuPrioMask), .cpuRunPrio(cpuRunPrio),
    .distGrpEn(distGrpEn), .cpuGrpEn(cpuGrpEn), .cpuFiqEn(cpuFiqEn),
    .strobe(strobe)
  );
endmodule

// File: rtl/prioArbChecker.sv
module prioArbChecker #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CPU  = 2,
  parameter int NUM_PRIV = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_CPU*NUM_SRC-1:0] srcPending,
  input logic [NUM_CPU*8-1:0]       cpuPrioMask,
  input logic [NUM_CPU*9-1:0]       cpuRunPrio,
  input logic [1:0]                 distGrpEn,
  input logic [NUM_CPU-1:0]         cpuFiqEn,
  input logic [NUM_CPU*10-1:0]      curPendId,
  input logic [NUM_CPU-1:0]         irqOut,
  input logic [NUM_CPU-1:0]         fiqOut
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_none_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
      (srcPending[c*NUM_SRC +: NUM_SRC] == '0) |=>
        (curPendId[c*10 +: 10] == 10'd1023 && !irqOut[c] && !fiqOut[c]));

    assert_mask_closed_R5: assert property (@(posedge clk) disable iff (!rstN)
      (cpuPrioMask[c*8 +: 8] == 8'd0) |=> (curPendId[c*10 +: 10] == 10'd1023));

    assert_run_closed_R6: assert property (@(posedge clk) disable iff (!rstN)
      (cpuRunPrio[c*9 +: 9] == 9'd0) |=> (!irqOut[c] && !fiqOut[c]));

    assert_line_has_id_R6: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut[c] || fiqOut[c]) |-> (curPendId[c*10 +: 10] != 10'd1023));

    assert_groups_off_R7: assert property (@(posedge clk) disable iff (!rstN)
      (distGrpEn == 2'b00) |=> (!irqOut[c] && !fiqOut[c]));

    assert_fast_needs_en_R8: assert property (@(posedge clk) disable iff (!rstN)
      fiqOut[c] |-> $past(cpuFiqEn[c]));

    assert_one_line_R8: assert property (@(posedge clk) disable iff (!rstN)
      $countones({irqOut[c], fiqOut[c]}) <= 1);
  end
endmodule

bind prioArbiter prioArbChecker #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PRIV(NUM_PRIV)) u_chk (
  .clk(clk), .rstN(rstN), .srcPending(srcPending), .cpuPrioMask(cpuPrioMask),
  .cpuRunPrio(cpuRunPrio), .distGrpEn(distGrpEn), .cpuFiqEn(cpuFiqEn),
  .curPendId(curPendId), .irqOut(irqOut), .fiqOut(fiqOut)
);

// File: tb/tb_prioArbiter.sv
module tb_prioArbiter;
  localparam int NS = 64;
  localparam int NC = 2;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic en [NC][NS];
  logic pd [NC][NS];
  logic ac [NC][NS];
  logic gp [NC][NS];
  logic tg [NS][NC];
  logic [7:0] ps [NS];
  logic [7:0] pp [NC][NP];
  logic [7:0] mask [NC];
  logic [8:0] run [NC];
  logic [1:0] dg;
  logic [1:0] cg [NC];
  logic       fe [NC];

  logic [NC*NS-1:0]      srcEnable, srcPending, srcActive, srcGroup;
  logic [(NS-NP)*NC-1:0] sharedTarget;
  logic [(NS-NP)*8-1:0]  sharedPrio;
  logic [NC*NP*8-1:0]    privPrio;
  logic [NC*8-1:0]       cpuPrioMask;
  logic [NC*9-1:0]       cpuRunPrio;
  logic [NC*2-1:0]       cpuGrpEn;
  logic [NC-1:0]         cpuFiqEn;
  logic [NC*10-1:0]      curPendId;
  logic [NC-1:0]         irqOut, fiqOut;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < NS; s++) begin
        srcEnable[c*NS+s]  = en[c][s];
        srcPending[c*NS+s] = pd[c][s];
        srcActive[c*NS+s]  = ac[c][s];
        srcGroup[c*NS+s]   = gp[c][s];
      end
      for (int s = 0; s < NP; s++) privPrio[(c*NP+s)*8 +: 8] = pp[c][s];
      cpuPrioMask[c*8 +: 8] = mask[c];
      cpuRunPrio[c*9 +: 9]  = run[c];
      cpuGrpEn[c*2 +: 2]    = cg[c];
      cpuFiqEn[c]           = fe[c];
    end
    for (int s = NP; s < NS; s++) begin
      sharedPrio[(s-NP)*8 +: 8] = ps[s];
      for (int c = 0; c < NC; c++) sharedTarget[(s-NP)*NC+c] = tg[s][c];
    end
  end

  prioArbiter #(.NUM_SRC(NS), .NUM_CPU(NC), .NUM_PRIV(NP)) dut (
    .clk(clk), .rstN(rstN), .srcEnable(srcEnable), .srcPending(srcPending),
    .srcActive(srcActive), .srcGroup(srcGroup), .sharedTarget(sharedTarget),
    .sharedPrio(sharedPrio), .privPrio(privPrio), .cpuPrioMask(cpuPrioMask),
    .cpuRunPrio(cpuRunPrio), .distGrpEn(distGrpEn_w), .cpuGrpEn(cpuGrpEn),
    .cpuFiqEn(cpuFiqEn), .curPendId(curPendId), .irqOut(irqOut), .fiqOut(fiqOut)
  );
  logic [1:0] distGrpEn_w;
  assign distGrpEn_w = dg;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic clearAll();
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < NS; s++) begin
        en[c][s] = 1'b0; pd[c][s] = 1'b0; ac[c][s] = 1'b0; gp[c][s] = 1'b1;
      end
      for (int s = 0; s < NP; s++) pp[c][s] = 8'h80;
      mask[c] = 8'hFF; run[c] = 9'h100; cg[c] = 2'b11; fe[c] = 1'b0;
    end
    for (int s = 0; s < NS; s++) begin
      ps[s] = 8'h80;
      for (int c = 0; c < NC; c++) tg[s][c] = 1'b1;
    end
    dg = 2'b11;
  endtask

  // Behavioural reference: linear search, lowest ID kept on ties.
  task automatic refEval(input int c, output int id, output bit irq, output bit fiq);
    int bestP, bestI, bestG, p;
    bit line;
    bestP = 256; bestI = 1023; bestG = 0;
    for (int s = 0; s < NS; s++) begin
      if (en[c][s] && pd[c][s] && !ac[c][s] && (s < NP || tg[s][c])) begin
        p = (s < NP) ? int'(pp[c][s]) : int'(ps[s]);
        if (p < bestP) begin bestP = p; bestI = s; bestG = int'(gp[c][s]); end
      end
    end
    id   = (bestP < int'(mask[c])) ? bestI : 1023;
    line = (bestP < int'(mask[c])) && (bestP < int'(run[c])) &&
           dg[bestG] && cg[c][bestG];
    fiq  = line && bestG == 0 && fe[c];
    irq  = line && !fiq;
  endtask

  task automatic compareAll(input string tag);
    int eid; bit eirq, efiq;
    for (int c = 0; c < NC; c++) begin
      refEval(c, eid, eirq, efiq);
      tests++;
      if (int'(curPendId[c*10 +: 10]) != eid || irqOut[c] != eirq || fiqOut[c] != efiq) begin
        fails++;
        $display("FAIL %s cpu%0d: got id=%0d irq=%0b fiq=%0b, expected id=%0d irq=%0b fiq=%0b",
                 tag, c, curPendId[c*10 +: 10], irqOut[c], fiqOut[c], eid, eirq, efiq);
      end
    end
  endtask

  // Inputs change 2 ns after a rising edge; outputs are compared 2 ns
  // after the next rising edge, which registered those inputs.
  task automatic step(input string tag);
    @(posedge clk); #2;
    compareAll(tag);
  endtask

  initial begin
    clearAll();
    repeat (3) @(posedge clk);
    #2;
    tests++;
    if (curPendId != {NC{10'd1023}} || irqOut != '0 || fiqOut != '0) begin
      fails++;
      $display("FAIL R10 reset: got id=%h irq=%b fiq=%b, expected all 1023 and low",
               curPendId, irqOut, fiqOut);
    end
    rstN = 1'b1;
    step("R4");

    // R1: qualification
    pd[0][40] = 1; pd[1][40] = 1; ps[40] = 8'h50;
    step("R1");
    en[0][40] = 1; en[1][40] = 1;
    step("R1");
    ac[0][40] = 1;
    step("R1");
    ac[0][40] = 0;

    // R2: routing of shared vs private
    tg[40][1] = 0;
    step("R2");
    en[1][5] = 1; pd[1][5] = 1; pp[1][5] = 8'h60;
    step("R2");

    // R3: priority order and ties
    clearAll();
    en[0][33] = 1; pd[0][33] = 1; ps[33] = 8'h40;
    en[0][50] = 1; pd[0][50] = 1; ps[50] = 8'h20;
    step("R3");
    ps[33] = 8'h20;
    step("R3");
    en[0][2] = 1; pd[0][2] = 1; pp[0][2] = 8'h20;
    step("R3");

    // R5: mask gate at equality and one above
    mask[0] = 8'h20;
    step("R5");
    mask[0] = 8'h21;
    step("R5");

    // R6: running priority gate
    run[0] = 9'h020;
    step("R6");
    run[0] = 9'h021;
    step("R6");
    run[0] = 9'h100;

    // R7 and R8: group routing
    gp[0][2] = 0;
    dg = 2'b10;
    step("R7");
    dg = 2'b11; cg[0] = 2'b10;
    step("R7");
    cg[0] = 2'b11;
    step("R8");
    fe[0] = 1;
    step("R8");
    gp[0][2] = 1;
    step("R8");

    // R9: banked private priority vs common shared priority
    clearAll();
    for (int c = 0; c < NC; c++) begin
      en[c][3] = 1; pd[c][3] = 1; en[c][40] = 1; pd[c][40] = 1;
    end
    pp[0][3] = 8'h10; pp[1][3] = 8'h90; ps[40] = 8'h50;
    step("R9");

    // R10 plus all rules under random state
    for (int n = 0; n < 400; n++) begin
      for (int c = 0; c < NC; c++) begin
        for (int s = 0; s < NS; s++) begin
          en[c][s] = ($urandom % 4) != 0;
          pd[c][s] = ($urandom % 6) == 0;
          ac[c][s] = ($urandom % 6) == 0;
          gp[c][s] = 1'($urandom);
        end
        for (int s = 0; s < NP; s++) pp[c][s] = 8'(($urandom % 8) * 32);
        mask[c] = 8'($urandom);
        run[c]  = ($urandom % 4 == 0) ? 9'h100 : 9'($urandom % 256);
        cg[c]   = 2'($urandom);
        fe[c]   = 1'($urandom);
      end
      for (int s = 0; s < NS; s++) begin
        ps[s] = 8'(($urandom % 8) * 32);
        for (int c = 0; c < NC; c++) tg[s][c] = 1'($urandom);
      end
      dg = ($urandom % 3 == 0) ? 2'($urandom) : 2'b11;
      step("R10");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule